// File: doc/BRIEF.md
# Soft-Start Trimmed Reference Sequencer

This block produces the digital code for the reference of a power supply's main error amplifier. One LSB of the code is 1 mV. While the start enable is low, the code is zero. When the enable goes high, the code climbs from zero towards the nominal setpoint in equal steps, one step per fixed number of clock cycles.

After the last step, the code settles on the trimmed setpoint. This is the nominal value plus a signed trim offset taken from a small two's-complement input. A done flag marks the settled phase.

The climb never goes above the trimmed setpoint. A negative trim can put the setpoint below the upper ramp steps. In that case the code holds at the setpoint until the ramp ends, so the ramp has no downward step and no overshoot. Dropping the enable returns the code to zero at once, and raising it again starts a fresh ramp from zero.

With the defaults (64 steps of 39 mV, 12 500 cycles per step), a 100 MHz clock gives a ramp of about 8 ms to a 2500 mV setpoint. The trim weight is 16 mV per LSB.

Top module: `soft_start_ref`

## Requirements
- R1: While reset is high, and on the first cycle after it, `dac_code` is 0 and `ramp_done` is 0.
- R2: A clock edge that samples `start_enable` low makes `dac_code` 0 and `ramp_done` 0 from that edge on.
- R3: Take the first edge that samples `start_enable` high as edge 0. After edge j, where j is less than STEPS×TICKS_PER_STEP, `dac_code` equals floor(j/TICKS_PER_STEP)×STEP_MV, limited as R4 states.
- R4: While `ramp_done` is 0, `dac_code` never exceeds the trimmed target. The target is NOMINAL_MV + TRIM_LSB_MV×t, where t is `trim` read as a two's-complement integer. A ramp level above the target is replaced by the target.
- R5: While the enable stays high and `trim` is constant, `dac_code` never decreases. During the ramp it rises by at most STEP_MV per cycle.
- R6: `ramp_done` rises after edge STEPS×TICKS_PER_STEP. From then on, `dac_code` equals the trimmed target. With the defaults, trim code 4'b0111 gives 2612 and 4'b1000 gives 2372.
- R7: While `ramp_done` is 1 and the enable stays high, `ramp_done` stays 1. A change of `trim` shows in `dac_code` after the next clock edge.
- R8: Dropping `start_enable`, even for one cycle in the middle of a ramp, discards the ramp's progress. The next ramp begins again from code 0 with full-length steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_enable | input | 1 | High requests ramp then hold; low forces code 0 |
| trim | input | TRIM_W | Two's-complement setpoint offset, TRIM_LSB_MV per LSB |
| dac_code | output | CODE_W | Reference code, 1 mV per LSB |
| ramp_done | output | 1 | High once the ramp has finished and the trimmed target is held |

## Verification
The bench builds the block with 3 cycles per step and keeps the default 64 steps, 39 mV step, 2500 mV nominal and 16 mV trim weight. A complete ramp then lasts under 200 cycles. This lets the bench sweep all 16 trim codes and compare every cycle of every ramp against an arithmetic model.

The sweep includes the most negative trim. Its target of 2372 falls below the last ramp steps, so the clamp is exercised. Single-cycle enable drops in the middle of a ramp and trim changes during the hold phase also fall inside the run.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RAMP = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    localparam int STEP_IDX_W = 16;

    typedef struct packed {
        phase_e                  phase;
        logic [STEP_IDX_W-1:0]   step;
    } ramp_pos_t;

    // Trimmed setpoint in mV for a signed trim value.
    function automatic int trimmed_target(input int nominal_mv,
                                          input int lsb_mv,
                                          input int trim_val);
        return nominal_mv + lsb_mv * trim_val;
    endfunction

    // Ramp level for a step index, limited by the target and floored at 0.
    function automatic int ramp_level(input int step_idx,
                                      input int step_mv,
                                      input int target_mv);
        int lvl;
        lvl = step_idx * step_mv;
        if (lvl > target_mv) lvl = target_mv;
        if (lvl < 0) lvl = 0;
        return lvl;
    endfunction

endpackage

// File: rtl/ssr_timebase.sv
module ssr_timebase #(
    parameter int TICKS_PER_STEP = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic step_tick
);
    localparam int TICK_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_STEP - 1);

    logic [TICK_W-1:0] tick_q;

    assign step_tick = run && (tick_q == TICK_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tick_q <= '0;
        end else if (tick_q == TICK_LAST) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

endmodule

// File: rtl/ssr_step_ctrl.sv
module ssr_step_ctrl
    import ssr_pkg::*;
#(
    parameter int STEPS = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      step_tick,
    output ramp_pos_t pos_cur,
    output ramp_pos_t pos_nxt
);
    localparam logic [STEP_IDX_W-1:0] STEP_LAST = STEP_IDX_W'(STEPS - 1);

    // R8: any low enable drops the sequence back to idle with step 0.
    always_comb begin
        pos_nxt = pos_cur;
        if (!enable) begin
            pos_nxt.phase = PH_IDLE;
            pos_nxt.step  = '0;
        end else begin
            unique case (pos_cur.phase)
                PH_IDLE: begin
                    pos_nxt.phase = PH_RAMP;
                    pos_nxt.step  = '0;
                end
                PH_RAMP: begin
                    if (step_tick) begin
                        if (pos_cur.step == STEP_LAST) begin
                            pos_nxt.phase = PH_HOLD;
                        end else begin
                            pos_nxt.step = pos_cur.step + 1'b1;
                        end
                    end
                end
                PH_HOLD: pos_nxt = pos_cur;
                default: begin
                    pos_nxt.phase = PH_IDLE;
                    pos_nxt.step  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_cur.phase <= PH_IDLE;
            pos_cur.step  <= '0;
        end else begin
            pos_cur <= pos_nxt;
        end
    end

endmodule

// File: rtl/ssr_code_gen.sv
module ssr_code_gen
    import ssr_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int TRIM_W      = 4,
    parameter int STEP_MV     = 39,
    parameter int NOMINAL_MV  = 2500,
    parameter int TRIM_LSB_MV = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ramp_pos_t         pos_nxt,
    input  logic [TRIM_W-1:0] trim,
    output logic [CODE_W-1:0] code,
    output logic              done
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    int                target_mv;
    int                level_mv;
    logic [CODE_W-1:0] code_nxt;

    // R4/R6: target from the sign-extended trim; ramp level limited by it.
    always_comb begin
        target_mv = trimmed_target(NOMINAL_MV, TRIM_LSB_MV, int'($signed(trim)));
        unique case (pos_nxt.phase)
            PH_RAMP: level_mv = ramp_level(int'(pos_nxt.step), STEP_MV, target_mv);
            PH_HOLD: level_mv = (target_mv < 0) ? 0 : target_mv;
            default: level_mv = 0;
        endcase
        if (level_mv > CODE_MAX) begin
            code_nxt = CODE_W'(CODE_MAX);
        end else begin
            code_nxt = CODE_W'(level_mv);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            done <= 1'b0;
        end else begin
            code <= code_nxt;
            done <= (pos_nxt.phase == PH_HOLD);
        end
    end

endmodule

// File: rtl/soft_start_ref.sv
module soft_start_ref
    import ssr_pkg::*;
#(
    parameter int CODE_W         = 12,
    parameter int TRIM_W         = 4,
    parameter int STEPS          = 64,
    parameter int STEP_MV        = 39,
    parameter int NOMINAL_MV     = 2500,
    parameter int TRIM_LSB_MV    = 16,
    parameter int TICKS_PER_STEP = 12500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_enable,
    input  logic [TRIM_W-1:0] trim,
    output logic [CODE_W-1:0] dac_code,
    output logic              ramp_done
);
    ramp_pos_t pos_cur;
    ramp_pos_t pos_nxt;
    logic      step_tick;
    logic      run;

    assign run = start_enable && (pos_cur.phase == PH_RAMP);

    ssr_timebase #(
        .TICKS_PER_STEP (TICKS_PER_STEP)
    ) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .step_tick (step_tick)
    );

    ssr_step_ctrl #(
        .STEPS (STEPS)
    ) u_step_ctrl (
        .clk       (clk),
        .rst       (rst),
        .enable    (start_enable),
        .step_tick (step_tick),
        .pos_cur   (pos_cur),
        .pos_nxt   (pos_nxt)
    );

    ssr_code_gen #(
        .CODE_W      (CODE_W),
        .TRIM_W      (TRIM_W),
        .STEP_MV     (STEP_MV),
        .NOMINAL_MV  (NOMINAL_MV),
        .TRIM_LSB_MV (TRIM_LSB_MV)
    ) u_code_gen (
        .clk     (clk),
        .rst     (rst),
        .pos_nxt (pos_nxt),
        .trim    (trim),
        .code    (dac_code),
        .done    (ramp_done)
    );

endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
    parameter int CODE_W      = 12,
    parameter int TRIM_W      = 4,
    parameter int STEP_MV     = 39,
    parameter int NOMINAL_MV  = 2500,
    parameter int TRIM_LSB_MV = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start_enable,
    input logic [TRIM_W-1:0] trim,
    input logic [CODE_W-1:0] dac_code,
    input logic              ramp_done
);
    logic [TRIM_W-1:0] trim_q;
    int                tgt;

    always_ff @(posedge clk) trim_q <= trim;

    assign tgt = NOMINAL_MV + TRIM_LSB_MV * int'($signed(trim_q));

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (dac_code == '0) && !ramp_done);

    // R2
    a_r2_disable_zero: assert property (@(posedge clk) disable iff (rst)
        !start_enable |=> (dac_code == '0) && !ramp_done);

    // R4
    a_r4_no_overshoot: assert property (@(posedge clk) disable iff (rst)
        !ramp_done |-> int'(dac_code) <= tgt);

    // R5
    a_r5_monotonic: assert property (@(posedge clk) disable iff (rst)
        (dac_code != '0) && (trim_q == $past(trim_q)) |-> dac_code >= $past(dac_code));

    // R5
    a_r5_step_bound: assert property (@(posedge clk) disable iff (rst)
        !ramp_done && (trim_q == $past(trim_q))
            |-> int'(dac_code) <= int'($past(dac_code)) + STEP_MV);

    // R6
    a_r6_hold_value: assert property (@(posedge clk) disable iff (rst)
        ramp_done |-> int'(dac_code) == tgt);

    // R7
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        ramp_done && start_enable |=> ramp_done);

endmodule

bind soft_start_ref ssr_checker #(
    .CODE_W      (CODE_W),
    .TRIM_W      (TRIM_W),
    .STEP_MV     (STEP_MV),
    .NOMINAL_MV  (NOMINAL_MV),
    .TRIM_LSB_MV (TRIM_LSB_MV)
) u_ssr_checker (
    .clk          (clk),
    .rst          (rst),
    .start_enable (start_enable),
    .trim         (trim),
    .dac_code     (dac_code),
    .ramp_done    (ramp_done)
);

// File: tb/soft_start_ref_tb.sv
`timescale 1ns/1ps
module soft_start_ref_tb;
    localparam int CODE_W   = 12;
    localparam int TRIM_W   = 4;
    localparam int STEPS    = 64;
    localparam int STEP_MV  = 39;
    localparam int NOM_MV   = 2500;
    localparam int LSB_MV   = 16;
    localparam int TICKS    = 3;
    localparam int RAMP_LEN = STEPS * TICKS;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b0;
    logic [TRIM_W-1:0] trim = '0;
    logic [CODE_W-1:0] dac_code;
    logic              ramp_done;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    soft_start_ref #(
        .CODE_W (CODE_W), .TRIM_W (TRIM_W), .STEPS (STEPS), .STEP_MV (STEP_MV),
        .NOMINAL_MV (NOM_MV), .TRIM_LSB_MV (LSB_MV), .TICKS_PER_STEP (TICKS)
    ) u_dut (
        .clk (clk), .rst (rst), .start_enable (en), .trim (trim),
        .dac_code (dac_code), .ramp_done (ramp_done)
    );

    function automatic int target_of(input logic [TRIM_W-1:0] t);
        return NOM_MV + LSB_MV * int'($signed(t));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Full ramp from idle with trim t; tag names the requirement for step checks.
    task automatic run_ramp(input logic [TRIM_W-1:0] t, input string tag);
        int prev;
        int tgt;
        @(negedge clk);
        trim = t;
        en   = 1'b1;
        prev = 0;
        tgt  = target_of(t);
        for (int j = 0; j < RAMP_LEN + 3; j++) begin
            int s;
            int e;
            @(posedge clk);
            #1;
            s = j / TICKS;
            if (s >= STEPS) begin
                chk("R6 hold code", int'(dac_code), tgt);
                chk("R6 done", int'(ramp_done), 1);
            end else begin
                e = s * STEP_MV;
                if (e > tgt) begin
                    chk("R4 clamp", int'(dac_code), tgt);
                end else begin
                    chk(tag, int'(dac_code), e);
                end
                chk("R6 not done", int'(ramp_done), 0);
            end
            checks++;
            if (int'(dac_code) < prev) begin
                fails++;
                $display("FAIL R5: actual %0d expected >= %0d", dac_code, prev);
            end
            prev = int'(dac_code);
        end
    endtask

    task automatic drop_enable();
        @(negedge clk);
        en = 1'b0;
        @(posedge clk);
        #1;
        chk("R2 code", int'(dac_code), 0);
        chk("R2 done", int'(ramp_done), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 code in reset", int'(dac_code), 0);
        chk("R1 done in reset", int'(ramp_done), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 code after reset", int'(dac_code), 0);
        chk("R1 done after reset", int'(ramp_done), 0);

        // Sweep every trim code through a full ramp.
        for (int t = 0; t < (1 << TRIM_W); t++) begin
            run_ramp(TRIM_W'(t), "R3 ramp");
            drop_enable();
        end

        // R7: trim changes during hold.
        run_ramp(4'b0000, "R3 ramp");
        @(negedge clk);
        trim = 4'b0111;
        @(posedge clk);
        #1;
        chk("R7 trim +7", int'(dac_code), 2612);
        chk("R7 done kept", int'(ramp_done), 1);
        @(negedge clk);
        trim = 4'b1000;
        @(posedge clk);
        #1;
        chk("R7 trim -8", int'(dac_code), 2372);
        chk("R7 done kept", int'(ramp_done), 1);

        // R8: single-cycle enable drop mid-ramp, then full restart.
        drop_enable();
        @(negedge clk);
        trim = 4'b0011;
        en   = 1'b1;
        repeat (100) @(posedge clk);
        #1;
        chk("R8 mid-ramp level", int'(dac_code), (99 / TICKS) * STEP_MV);
        drop_enable();
        run_ramp(4'b0011, "R8 restart");
        drop_enable();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule